// File: doc/BRIEF.md
# GPIO Interrupt Edge and Noise Filter Unit

This block sits between the synchronised input levels of the interrupt-capable GPIO lines and an upstream interrupt controller. It drives one interrupt output for each line. Each line has three control bits: an enable bit, a mode bit and a filter enable bit. The mode bit selects between passing the level through and detecting both edges. The filter enable bit switches in a noise filter. One period value sets the filter length, and every line uses it. The filter acts only on the interrupt path. The GPIO data path is not part of this unit, so data reads are never debounced.

The upstream controller sees only falling edges on a line in both-edge mode. For that reason the output of such a line rests high and drops low for exactly one cycle each time its filtered level changes, whether the change is rising or falling. Edges are detected only on the filtered signal. A line in both-edge mode with its filter switched off therefore never produces an event. Software programs the four control registers over a simple 32-bit register bus with word offsets.

Top module: `gpio_irqf_top`

## Requirements
- R1: After reset, the enable, mode and filter enable registers read 0, the period register reads 0xFF, and every `irq_out` bit is 0.
- R2: Enable is at offset 0x90, mode at 0x94, filter enable at 0x98 and filter period at 0x9C. Line n is bit n of the first three registers. The period uses bits 7:0 of its register. Bits at or above NUM_LINES and above bit 7 of the period read 0. Any other offset reads 0 and ignores writes. Read data appears on `bus_rdata` in the cycle after the read request.
- R3: A line whose enable bit is 0 drives no event. Its output is 0 in level mode (mode bit 0) and 1 in both-edge mode (mode bit 1), whatever its input does.
- R4: A line that is enabled, in level mode and with its filter off drives `irq_out` equal to its `line_in` value of one cycle earlier.
- R5: When the filter is on, the filtered level takes a new input value only after the input has differed from the current filtered level on P consecutive clock edges, where P is the period value. A period of 0 acts as 1. An enabled line in level mode with the filter on outputs the filtered level. A glitch shorter than P cycles has no effect on the output.
- R6: An enabled line in both-edge mode with the filter on holds `irq_out` high. It drives `irq_out` low for one cycle on the edge at which its filtered level changes, for rising and for falling changes alike.
- R7: A line in both-edge mode with its filter off keeps `irq_out` at 1 whatever its input does.
- R8: Every line uses the one period value, and activity on one line does not change the output of any other line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Register access request for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| line_in | input | NUM_LINES | Synchronised GPIO input levels |
| irq_out | output | NUM_LINES | Per-line interrupt output to the upstream controller |

## Verification
The assertions assume that `line_in` is already synchronous to `clk` and changes only between clock edges. They also assume that reset is released away from a clock edge, so that the one-cycle history they compare against always comes from a cycle after reset. The bench drives every input at the falling clock edge, releases reset at a falling edge and samples at falling edges. It changes the control registers only while the affected lines are quiet, so no mode change lands in the middle of a filter count it measures.

// File: rtl/gpio_irqf_pkg.sv
package gpio_irqf_pkg;

   localparam int unsigned MAX_LINES  = 24;
   localparam int unsigned BUS_W      = 32;
   localparam int unsigned ADDR_W     = 8;

   localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h90;
   localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h94;
   localparam logic [ADDR_W-1:0] OFS_FILTEN = 8'h98;
   localparam logic [ADDR_W-1:0] OFS_PERIOD = 8'h9C;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_ENABLE,
      SEL_MODE,
      SEL_FILTEN,
      SEL_PERIOD
   } reg_sel_e;

   function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
      reg_sel_e s;
      case (a)
         OFS_ENABLE: s = SEL_ENABLE;
         OFS_MODE:   s = SEL_MODE;
         OFS_FILTEN: s = SEL_FILTEN;
         OFS_PERIOD: s = SEL_PERIOD;
         default:    s = SEL_NONE;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/gpio_irqf_regs.sv
module gpio_irqf_regs
   import gpio_irqf_pkg::*;
#(
   parameter int unsigned NUM_LINES  = 24,
   parameter int unsigned PERIOD_W   = 8,
   parameter int unsigned PERIOD_RST = 255
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_req,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   output logic [NUM_LINES-1:0] en_o,
   output logic [NUM_LINES-1:0] mode_o,
   output logic [NUM_LINES-1:0] fen_o,
   output logic [PERIOD_W-1:0]  period_o
);

   localparam logic [PERIOD_W-1:0] PERIOD_INIT = PERIOD_W'(PERIOD_RST);

   logic [NUM_LINES-1:0] en_q, mode_q, fen_q;
   logic [PERIOD_W-1:0]  period_q;
   logic [BUS_W-1:0]     en_rd, mode_rd, fen_rd, period_rd;
   logic [BUS_W-1:0]     rd_mux, rd_q;
   reg_sel_e             sel;

   assign sel = decode_addr(bus_addr);

   for (genvar b = 0; b < BUS_W; b++) begin : g_rd_lines
      if (b < NUM_LINES) begin : g_live
         assign en_rd[b]   = en_q[b];
         assign mode_rd[b] = mode_q[b];
         assign fen_rd[b]  = fen_q[b];
      end else begin : g_zero
         assign en_rd[b]   = 1'b0;
         assign mode_rd[b] = 1'b0;
         assign fen_rd[b]  = 1'b0;
      end
   end

   for (genvar b = 0; b < BUS_W; b++) begin : g_rd_period
      if (b < PERIOD_W) begin : g_live
         assign period_rd[b] = period_q[b];
      end else begin : g_zero
         assign period_rd[b] = 1'b0;
      end
   end

   always_comb begin
      case (sel)
         SEL_ENABLE: rd_mux = en_rd;
         SEL_MODE:   rd_mux = mode_rd;
         SEL_FILTEN: rd_mux = fen_rd;
         SEL_PERIOD: rd_mux = period_rd;
         default:    rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= '0;
         mode_q   <= '0;
         fen_q    <= '0;
         period_q <= PERIOD_INIT;
         rd_q     <= '0;
      end else begin
         if (bus_req && bus_wr) begin
            case (sel)
               SEL_ENABLE: en_q     <= bus_wdata[NUM_LINES-1:0];
               SEL_MODE:   mode_q   <= bus_wdata[NUM_LINES-1:0];
               SEL_FILTEN: fen_q    <= bus_wdata[NUM_LINES-1:0];
               SEL_PERIOD: period_q <= bus_wdata[PERIOD_W-1:0];
               default:    ;
            endcase
         end
         rd_q <= (bus_req && !bus_wr) ? rd_mux : '0;
      end
   end

   assign bus_rdata = rd_q;
   assign en_o      = en_q;
   assign mode_o    = mode_q;
   assign fen_o     = fen_q;
   assign period_o  = period_q;

endmodule

// File: rtl/gpio_irqf_filter.sv
module gpio_irqf_filter #(
   parameter int unsigned PERIOD_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                din,
   input  logic                fen,
   input  logic [PERIOD_W-1:0] period,
   output logic                lvl_o,
   output logic                lvl_next_o,
   output logic                accept_o
);

   logic                lvl_q;
   logic [PERIOD_W-1:0] cnt_q;
   logic [PERIOD_W-1:0] lim;
   logic                differ;
   logic                accept;

   assign lim    = (period == '0) ? '0 : period - 1'b1;
   assign differ = din ^ lvl_q;
   assign accept = fen & differ & (cnt_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         cnt_q <= '0;
      end else if (!fen) begin
         lvl_q <= din;
         cnt_q <= '0;
      end else if (!differ) begin
         cnt_q <= '0;
      end else if (accept) begin
         lvl_q <= din;
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign lvl_o      = lvl_q;
   assign lvl_next_o = fen ? (accept ? din : lvl_q) : din;
   assign accept_o   = accept;

endmodule

// File: rtl/gpio_irqf_outstage.sv
module gpio_irqf_outstage (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic mode,
   input  logic lvl_next,
   input  logic accept,
   output logic irq_o
);

   logic irq_d, irq_q;

   always_comb begin
      if (mode) irq_d = ~(en & accept);
      else      irq_d = en & lvl_next;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= irq_d;
   end

   assign irq_o = irq_q;

endmodule

// File: rtl/gpio_irqf_top.sv
module gpio_irqf_top
   import gpio_irqf_pkg::*;
#(
   parameter int unsigned NUM_LINES  = 24,
   parameter int unsigned PERIOD_W   = 8,
   parameter int unsigned PERIOD_RST = 255
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_req,
   input  logic                 bus_wr,
   input  logic [7:0]           bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   input  logic [NUM_LINES-1:0] line_in,
   output logic [NUM_LINES-1:0] irq_out
);

   if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_lines
      $error("gpio_irqf_top: NUM_LINES out of range");
   end
   if (PERIOD_W < 1 || PERIOD_W > BUS_W) begin : g_bad_period_w
      $error("gpio_irqf_top: PERIOD_W out of range");
   end
   if (PERIOD_RST >= (64'd1 << PERIOD_W)) begin : g_bad_period_rst
      $error("gpio_irqf_top: PERIOD_RST does not fit PERIOD_W");
   end

   logic [NUM_LINES-1:0] en_q, mode_q, fen_q;
   logic [PERIOD_W-1:0]  period_q;
   logic [NUM_LINES-1:0] filt_lvl, lvl_next, accept;

   gpio_irqf_regs #(
      .NUM_LINES  (NUM_LINES),
      .PERIOD_W   (PERIOD_W),
      .PERIOD_RST (PERIOD_RST)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_req   (bus_req),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .en_o      (en_q),
      .mode_o    (mode_q),
      .fen_o     (fen_q),
      .period_o  (period_q)
   );

   for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
      gpio_irqf_filter #(
         .PERIOD_W (PERIOD_W)
      ) filt_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .din        (line_in[n]),
         .fen        (fen_q[n]),
         .period     (period_q),
         .lvl_o      (filt_lvl[n]),
         .lvl_next_o (lvl_next[n]),
         .accept_o   (accept[n])
      );

      gpio_irqf_outstage out_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .en       (en_q[n]),
         .mode     (mode_q[n]),
         .lvl_next (lvl_next[n]),
         .accept   (accept[n]),
         .irq_o    (irq_out[n])
      );
   end

endmodule

// File: rtl/gpio_irqf_chk.sv
module gpio_irqf_chk #(
   parameter int unsigned NUM_LINES = 24
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] line_in,
   input logic [NUM_LINES-1:0] irq_out,
   input logic [NUM_LINES-1:0] en_q,
   input logic [NUM_LINES-1:0] mode_q,
   input logic [NUM_LINES-1:0] fen_q,
   input logic [NUM_LINES-1:0] filt_lvl
);

   AST_MASK_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_out & ~$past(en_q) & ~$past(mode_q)) == '0)); // R3

   AST_EDGE_NO_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
      ((~irq_out & $past(mode_q) & ~$past(fen_q)) == '0)); // R7

   AST_RAW_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (((irq_out ^ $past(line_in)) & $past(en_q & ~mode_q & ~fen_q)) == '0)); // R4

   AST_FILT_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (((filt_lvl ^ $past(filt_lvl)) & (filt_lvl ^ $past(line_in))) == '0)); // R5

   AST_EDGE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (((~irq_out ^ (filt_lvl ^ $past(filt_lvl))) & $past(en_q & mode_q & fen_q)) == '0)); // R6

endmodule

bind gpio_irqf_top gpio_irqf_chk #(.NUM_LINES(NUM_LINES)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .line_in  (line_in),
   .irq_out  (irq_out),
   .en_q     (en_q),
   .mode_q   (mode_q),
   .fen_q    (fen_q),
   .filt_lvl (filt_lvl)
);

// File: tb/gpio_irqf_top_tb_top.sv
`timescale 1ns/1ps
module gpio_irqf_top_tb_top;

   localparam int NL = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_req = 1'b0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NL-1:0] line_in = '0;
   logic [NL-1:0] irq_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   gpio_irqf_top #(.NUM_LINES(NL)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_req   (bus_req),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .line_in   (line_in),
      .irq_out   (irq_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_req = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_req = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_req = 1'b0;
      check(tag, bus_rdata, exp);
   endtask

   task automatic config_all(input logic [31:0] en, input logic [31:0] md,
                             input logic [31:0] fe, input logic [31:0] per);
      wr(8'h9C, per);
      wr(8'h98, fe);
      wr(8'h94, md);
      wr(8'h90, en);
   endtask

   task automatic t_reset;
      check("R1 irq_out after reset", 32'(irq_out), 32'h0);
      rd_check("R1 enable reset", 8'h90, 32'h0);
      rd_check("R1 mode reset", 8'h94, 32'h0);
      rd_check("R1 filter enable reset", 8'h98, 32'h0);
      rd_check("R1 period reset", 8'h9C, 32'hFF);
   endtask

   task automatic t_regs;
      wr(8'h90, 32'hFFFF_FFFF);
      rd_check("R2 enable width", 8'h90, 32'h00FF_FFFF);
      wr(8'h94, 32'h5EA5_A5A5);
      rd_check("R2 mode readback", 8'h94, 32'h00A5_A5A5);
      wr(8'h98, 32'h0012_3456);
      rd_check("R2 filter enable readback", 8'h98, 32'h0012_3456);
      wr(8'h9C, 32'h0000_01F3);
      rd_check("R2 period width", 8'h9C, 32'h0000_00F3);
      wr(8'h80, 32'hFFFF_FFFF);
      rd_check("R2 unmapped reads zero", 8'h80, 32'h0);
      rd_check("R2 unmapped write ignored", 8'h90, 32'h00FF_FFFF);
      config_all(32'h0, 32'h0, 32'h0, 32'h0);
   endtask

   task automatic t_raw;
      config_all(32'h1, 32'h0, 32'h0, 32'h4);
      line_in[0] = 1'b1;
      step(1);
      check("R4 raw rise", 32'(irq_out[0]), 32'h1);
      check("R8 other lines quiet", 32'(irq_out[NL-1:1]), 32'h0);
      line_in[0] = 1'b0;
      step(1);
      check("R4 raw fall", 32'(irq_out[0]), 32'h0);
   endtask

   task automatic t_mask;
      int bad;
      // line 0 masked level mode, line 1 masked both-edge with filter
      config_all(32'h0, 32'h2, 32'h2, 32'h1);
      bad = 0;
      for (int i = 0; i < 12; i++) begin
         line_in[0] = i[0];
         line_in[1] = i[1];
         step(1);
         if (irq_out[0] !== 1'b0) bad++;
         if (irq_out[1] !== 1'b1) bad++;
      end
      check("R3 masked lines stay inactive", 32'(bad), 32'h0);
      line_in[1:0] = 2'b00;
      step(2);
   endtask

   task automatic t_filter_level;
      int bad;
      config_all(32'h4, 32'h0, 32'h4, 32'h4);
      step(1);
      line_in[2] = 1'b1;
      step(3);
      check("R5 not yet accepted after P-1", 32'(irq_out[2]), 32'h0);
      step(1);
      check("R5 accepted after P", 32'(irq_out[2]), 32'h1);
      bad = 0;
      line_in[2] = 1'b0;
      step(2);
      if (irq_out[2] !== 1'b1) bad++;
      line_in[2] = 1'b1;
      for (int i = 0; i < 6; i++) begin
         step(1);
         if (irq_out[2] !== 1'b1) bad++;
      end
      check("R5 short glitch ignored", 32'(bad), 32'h0);
      wr(8'h9C, 32'h0);
      line_in[2] = 1'b0;
      step(1);
      check("R5 period zero acts as one", 32'(irq_out[2]), 32'h0);
   endtask

   task automatic t_edge;
      config_all(32'h8, 32'h8, 32'h8, 32'h3);
      step(1);
      check("R6 idle high", 32'(irq_out[3]), 32'h1);
      line_in[3] = 1'b1;
      step(2);
      check("R6 rise not before P", 32'(irq_out[3]), 32'h1);
      step(1);
      check("R6 rise pulses low", 32'(irq_out[3]), 32'h0);
      step(1);
      check("R6 pulse one cycle", 32'(irq_out[3]), 32'h1);
      step(3);
      line_in[3] = 1'b0;
      step(3);
      check("R6 fall pulses low", 32'(irq_out[3]), 32'h0);
      step(1);
      check("R6 fall pulse one cycle", 32'(irq_out[3]), 32'h1);
   endtask

   task automatic t_edge_nofilt;
      int bad;
      config_all(32'h10, 32'h10, 32'h0, 32'h1);
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         line_in[4] = i[1];
         step(1);
         if (irq_out[4] !== 1'b1) bad++;
      end
      check("R7 no edge without filter", 32'(bad), 32'h0);
      line_in[4] = 1'b0;
   endtask

   task automatic t_shared;
      config_all(32'h60, 32'h0, 32'h60, 32'h2);
      step(1);
      line_in[5] = 1'b1;
      step(1);
      check("R8 shared period not yet", 32'(irq_out[6:5]), 32'h0);
      step(1);
      check("R8 line 5 accepted, line 6 untouched", 32'(irq_out[6:5]), 32'h1);
      line_in[6] = 1'b1;
      step(2);
      check("R8 line 6 same period", 32'(irq_out[6:5]), 32'h3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step(1);
      t_reset;
      t_regs;
      t_raw;
      t_mask;
      t_filter_level;
      t_edge;
      t_edge_nofilt;
      t_shared;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule